// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

The unit takes two binary floating-point operands and an 8-bit comparison code. One cycle later it gives a single condition bit for the status register and a write strobe for that bit. The bit answers a relation between the operands: equal, not equal, greater, greater-or-equal, less, or less-or-equal. Each relation also has a variant that is true when the operands cannot be ordered, and one code tests only whether they can be ordered. The unit writes no general register and raises no exceptions.

The exponent and fraction widths are parameters. The defaults give the 32-bit single-precision format. The unit classifies each operand: it finds NaN, zero and sign. It then orders the two values by sign and magnitude, with +0 and -0 treated as the same value. The comparison code picks which relation drives the flag.

Top module: `fcmp_flag_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `flag_we` and `flag_val` are 0.
- R2: `flag_we` is 1 in the cycle after `cmp_valid` was 1 with a code in 0x08..0x0D or 0x28..0x2E. It is 0 after any other code and after any cycle with `cmp_valid` low.
- R3: Codes 0x08, 0x0A, 0x0B, 0x0C and 0x0D give eq, gt, ge, lt and le. Each gives a flag of 0 whenever either operand is NaN.
- R4: Code 0x09 (ne) gives a flag of 1 exactly when the operands are not equal, and that includes every case where either operand is NaN.
- R5: Equality and ordering follow numeric value: +0 equals -0, negative values order below positive ones, and infinities order beyond every finite value of the same sign.
- R6: Codes 0x28..0x2D give the relations of codes 0x08..0x0D, in the same order, ORed with "either operand is NaN".
- R7: Code 0x2E gives a flag of 1 exactly when at least one operand is NaN.
- R8: An operand is NaN when its exponent field is all ones and its fraction field is nonzero. An all-ones exponent with a zero fraction is an infinity and is ordered.
- R9: `flag_val` is 0 in every cycle in which `flag_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | Comparison request strobe |
| cmp_code | input | 8 | Comparison selector |
| opnd_a | input | 1+EXP_W+FRAC_W | First operand |
| opnd_b | input | 1+EXP_W+FRAC_W | Second operand |
| flag_we | output | 1 | Status flag write enable |
| flag_val | output | 1 | Status flag value |

## Verification
The bench builds the unit with a 3-bit exponent and a 2-bit fraction, so each operand is 6 bits. At that size all 4096 operand pairs run under each of the 13 valid codes. This covers every combination of signed zeros, subnormals, infinities and NaN payloads. The bench computes the expected flag from a scaled integer value of each operand, not from sign and magnitude fields. A separate sweep drives all 256 codes and idle cycles to check the write strobe.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    localparam int CODE_W = 8;

    // Relation selected by the low three bits of a valid code
    typedef enum logic [2:0] {
        REL_EQ = 3'd0,
        REL_NE = 3'd1,
        REL_GT = 3'd2,
        REL_GE = 3'd3,
        REL_LT = 3'd4,
        REL_LE = 3'd5
    } rel_e;

    typedef struct packed {
        logic known;       // code is one of the recognised ones
        logic or_unord;    // relation ORed with the NaN test
        logic unord_only;  // flag is the NaN test alone
        rel_e rel;
    } cmd_t;

    typedef struct packed {
        logic nan;
        logic zero;
        logic sign;
    } cls_t;

    typedef struct packed {
        logic unord;
        logic eq;
        logic lt;
        logic gt;
    } order_t;

    // Code bits [7:6] are 0, bit 4 is 0 and bit 3 is 1. Bit 5 picks the
    // NaN-inclusive family. Bits [2:0] pick the relation; 6 is the pure
    // NaN test and exists only in the NaN-inclusive family.
    function automatic cmd_t decode_code(input logic [CODE_W-1:0] code);
        cmd_t c;
        c.known      = 1'b0;
        c.or_unord   = 1'b0;
        c.unord_only = 1'b0;
        c.rel        = REL_EQ;
        if (code[7:6] == 2'b00 && !code[4] && code[3]) begin
            if (code[2:0] <= 3'd5) begin
                c.known    = 1'b1;
                c.or_unord = code[5];
                c.rel      = rel_e'(code[2:0]);
            end else if (code[2:0] == 3'd6 && code[5]) begin
                c.known      = 1'b1;
                c.unord_only = 1'b1;
            end
        end
        return c;
    endfunction

    function automatic logic pick_relation(input order_t o, input rel_e r);
        logic res;
        case (r)
            REL_EQ:  res = o.eq;
            REL_NE:  res = !o.eq;
            REL_GT:  res = o.gt;
            REL_GE:  res = o.gt | o.eq;
            REL_LT:  res = o.lt;
            REL_LE:  res = o.lt | o.eq;
            default: res = 1'b0;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] value,
    output cls_t         cls,
    output logic [W-2:0] mag
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    assign exp_f  = value[W-2:FRAC_W];
    assign frac_f = value[FRAC_W-1:0];
    assign mag    = value[W-2:0];

    always_comb begin
        cls.sign = value[W-1];
        cls.nan  = (&exp_f) && (|frac_f);
        cls.zero = (mag == '0);
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
#(
    parameter int MAG_W = 31
) (
    input  cls_t             cls_a,
    input  cls_t             cls_b,
    input  logic [MAG_W-1:0] mag_a,
    input  logic [MAG_W-1:0] mag_b,
    output order_t           ord
);
    logic both_zero;
    logic same_bits;
    logic raw_lt;

    assign both_zero = cls_a.zero && cls_b.zero;
    assign same_bits = (cls_a.sign == cls_b.sign) && (mag_a == mag_b);

    // Sign-magnitude less-than, valid only when the values differ
    always_comb begin
        if (cls_a.sign != cls_b.sign)
            raw_lt = cls_a.sign;
        else if (cls_a.sign)
            raw_lt = mag_a > mag_b;
        else
            raw_lt = mag_a < mag_b;
    end

    always_comb begin
        ord.unord = cls_a.nan || cls_b.nan;
        ord.eq    = !ord.unord && (both_zero || same_bits);
        ord.lt    = !ord.unord && !ord.eq && raw_lt;
        ord.gt    = !ord.unord && !ord.eq && !raw_lt;
    end
endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_valid,
    input  logic [CODE_W-1:0] cmp_code,
    input  logic [W-1:0]      opnd_a,
    input  logic [W-1:0]      opnd_b,
    output logic              flag_we,
    output logic              flag_val
);
    localparam int MAG_W = W - 1;

    logic [W-1:0]     opnds [2];
    cls_t             cls   [2];
    logic [MAG_W-1:0] mags  [2];
    order_t           ord;
    cmd_t             cmd;
    logic             flag_next;

    assign opnds[0] = opnd_a;
    assign opnds[1] = opnd_b;

    for (genvar i = 0; i < 2; i++) begin : g_cls
        fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .value (opnds[i]),
            .cls   (cls[i]),
            .mag   (mags[i])
        );
    end

    fcmp_order #(.MAG_W(MAG_W)) u_order (
        .cls_a (cls[0]),
        .cls_b (cls[1]),
        .mag_a (mags[0]),
        .mag_b (mags[1]),
        .ord   (ord)
    );

    assign cmd = decode_code(cmp_code);

    always_comb begin
        if (cmd.unord_only)
            flag_next = ord.unord;
        else
            flag_next = pick_relation(ord, cmd.rel) | (cmd.or_unord & ord.unord);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_we  <= 1'b0;
            flag_val <= 1'b0;
        end else begin
            flag_we  <= cmp_valid & cmd.known;
            flag_val <= cmp_valid & cmd.known & flag_next;
        end
    end
endmodule

// File: rtl/fcmp_flag_unit_checker.sv
module fcmp_flag_unit_checker #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input logic         clk,
    input logic         rst,
    input logic         cmp_valid,
    input logic [7:0]   cmp_code,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic         flag_we,
    input logic         flag_val
);
    logic a_nan, b_nan, any_nan, good_code;

    assign a_nan     = (&opnd_a[W-2:FRAC_W]) && (|opnd_a[FRAC_W-1:0]);
    assign b_nan     = (&opnd_b[W-2:FRAC_W]) && (|opnd_b[FRAC_W-1:0]);
    assign any_nan   = a_nan || b_nan;
    assign good_code = cmp_code inside {[8'h08:8'h0D], [8'h28:8'h2E]};

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!flag_we && !flag_val));

    p_we_on_good_r2: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && good_code) |=> flag_we);

    p_we_off_otherwise_r2: assert property (@(posedge clk) disable iff (rst)
        !(cmp_valid && good_code) |=> !flag_we);

    p_ordered_nan_false_r3: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && cmp_code inside {8'h08, [8'h0A:8'h0D]} && any_nan) |=> !flag_val);

    p_ne_nan_true_r4: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && cmp_code == 8'h09 && any_nan) |=> flag_val);

    p_variant_nan_true_r6: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && cmp_code inside {[8'h28:8'h2D]} && any_nan) |=> flag_val);

    p_pure_unord_r7: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && cmp_code == 8'h2E) |=> (flag_val == $past(any_nan)));

    p_flag_needs_we_r9: assert property (@(posedge clk) disable iff (rst)
        !flag_we |-> !flag_val);
endmodule

bind fcmp_flag_unit fcmp_flag_unit_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmp_valid (cmp_valid),
    .cmp_code  (cmp_code),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .flag_we   (flag_we),
    .flag_val  (flag_val)
);

// File: tb/fcmp_flag_unit_test.sv
module fcmp_flag_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int BE = 3;
    localparam int BF = 2;
    localparam int BW = 1 + BE + BF;
    localparam int NV = 1 << BW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmp_valid = 1'b0;
    logic [7:0]    cmp_code = 8'h00;
    logic [BW-1:0] opnd_a = '0;
    logic [BW-1:0] opnd_b = '0;
    logic          flag_we;
    logic          flag_val;

    int checks = 0;
    int fails  = 0;

    fcmp_flag_unit #(.EXP_W(BE), .FRAC_W(BF)) uut (
        .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_code(cmp_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .flag_we(flag_we), .flag_val(flag_val)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected values from scaled integer value of each operand
    function automatic int scaled(input logic [BW-1:0] v);
        int e = int'(v[BW-2:BF]);
        int f = int'(v[BF-1:0]);
        int m = (e == 0) ? f : ((f + (1 << BF)) << (e - 1));
        return v[BW-1] ? -m : m;
    endfunction

    function automatic bit is_nan(input logic [BW-1:0] v);
        return (v[BW-2:BF] == {BE{1'b1}}) && (v[BF-1:0] != 0);
    endfunction

    function automatic bit code_ok(input logic [7:0] c);
        return (c >= 8'h08 && c <= 8'h0D) || (c >= 8'h28 && c <= 8'h2E);
    endfunction

    function automatic bit ref_flag(input logic [7:0] c, input logic [BW-1:0] a,
                                    input logic [BW-1:0] b);
        bit un = is_nan(a) || is_nan(b);
        int ka = scaled(a);
        int kb = scaled(b);
        bit eq = !un && ka == kb;
        bit lt = !un && ka < kb;
        bit gt = !un && ka > kb;
        bit r;
        case (c[2:0])
            3'd0: r = eq;
            3'd1: r = !eq;
            3'd2: r = gt;
            3'd3: r = gt || eq;
            3'd4: r = lt;
            3'd5: r = lt || eq;
            default: r = 1'b0;
        endcase
        if (c == 8'h2E) return un;
        if (c[5]) return r || un;
        return r;
    endfunction

    function automatic string req_of(input logic [7:0] c);
        if (c == 8'h2E) return "R7";
        if (c[5]) return "R6";
        if (c == 8'h09) return "R4";
        return "R3/R5";
    endfunction

    task automatic check(input bit got, input bit exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic apply(input bit v, input logic [7:0] c, input logic [BW-1:0] a,
                         input logic [BW-1:0] b);
        @(negedge clk);
        cmp_valid = v; cmp_code = c; opnd_a = a; opnd_b = b;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] codes [13];
        for (int i = 0; i < 6; i++) begin
            codes[i]     = 8'h08 + 8'(i);
            codes[i + 6] = 8'h28 + 8'(i);
        end
        codes[12] = 8'h2E;

        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check(flag_we, 1'b0, "R1", "we during reset");
        check(flag_val, 1'b0, "R1", "flag during reset");
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check(flag_we, 1'b0, "R1", "we after reset");
        check(flag_val, 1'b0, "R1", "flag after reset");

        // R2: every code drives the strobe only when recognised
        for (int c = 0; c < 256; c++) begin
            apply(1'b1, 8'(c), 6'h04, 6'h08);
            check(flag_we, code_ok(8'(c)), "R2", $sformatf("we code %02h", c));
            if (!flag_we) check(flag_val, 1'b0, "R9", $sformatf("flag code %02h", c));
        end
        // R2: idle cycles with a good code
        for (int i = 0; i < 13; i++) begin
            apply(1'b0, codes[i], 6'h00, 6'h00);
            check(flag_we, 1'b0, "R2", "we while idle");
            check(flag_val, 1'b0, "R9", "flag while idle");
        end

        // R3..R8: exhaustive operand sweep for every code
        for (int i = 0; i < 13; i++) begin
            for (int a = 0; a < NV; a++) begin
                for (int b = 0; b < NV; b++) begin
                    apply(1'b1, codes[i], BW'(a), BW'(b));
                    check(flag_we, 1'b1, "R2", "we in sweep");
                    check(flag_val, ref_flag(codes[i], BW'(a), BW'(b)), req_of(codes[i]),
                          $sformatf("code %02h a %02h b %02h", codes[i], a, b));
                end
            end
        end

        // R5/R8 spot cases: signed zeros, infinity vs NaN
        apply(1'b1, 8'h08, 6'h00, 6'h20);
        check(flag_val, 1'b1, "R5", "+0 eq -0");
        apply(1'b1, 8'h0C, 6'h3C, 6'h1B);
        check(flag_val, 1'b1, "R5", "-inf lt max finite");
        apply(1'b1, 8'h2E, 6'h1C, 6'h3C);
        check(flag_val, 1'b0, "R8", "infinities are ordered");
        apply(1'b1, 8'h2E, 6'h1D, 6'h00);
        check(flag_val, 1'b1, "R8", "nonzero fraction is NaN");

        apply(1'b0, 8'h00, 6'h00, 6'h00);
        finish_run();
    end
endmodule